// File: doc/BRIEF.md
# Dual-address DMA channel engine

This block is one DMA channel. It copies a block of memory by reading operands from a source address and writing them to a destination address, over a single bus master port. Software programs a source address, a destination address, a byte count and a control word, then starts the channel with a self-clearing go bit. The channel can also be armed to start on a pulse of an external request pin. Before it asks for the bus, the channel checks that the addresses and the count agree with the programmed operand widths. If they do not, it reports a configuration error and moves nothing. The source and destination widths may differ. The channel then packs several narrow reads into one wide write, or splits one wide read into several narrow writes. A bandwidth limit makes the channel give the bus away for a cycle each time the remaining count crosses a programmable power-of-two boundary.

The sequencer has six states:
- `ST_IDLE` waits for a start.
- `ST_CHECK` runs the configuration check for one cycle.
- `ST_ACQUIRE` requests the bus and waits for grant.
- `ST_RD` runs source read cycles.
- `ST_WR` runs destination write cycles.
- `ST_YIELD` drops the request for one cycle.

The transitions are:
- IDLE→CHECK on a start.
- CHECK→IDLE on a bad configuration.
- CHECK→ACQUIRE on a good configuration.
- ACQUIRE→RD on grant.
- RD→WR when the last read of a unit is acknowledged.
- WR→RD when more units remain.
- WR→YIELD when a boundary is reached.
- WR→IDLE when the count reaches zero.
- RD/WR→IDLE on a bus error.
- YIELD→ACQUIRE always.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every register reads zero and `bus_req`, `bus_cyc` and `irq` are low. The registers sit at word index 0 (source address), 1 (destination address), 2 (byte count), 3 (control) and 4 (status), and read back what was written.
- R2: A run starts when control bit 0 (go) is written as 1, or when control bit 1 (external enable) is set and `dreq` is high for a cycle. The go bit reads back 0 once the run has been granted the bus or has been rejected. External enable alone, without `dreq`, causes no bus activity.
- R3: A read cycle drives the source address with `bus_wr` low and `bus_size` set to the source width. Control bits [5:4] hold the source width: 00 = 32-bit, 01 = 8-bit, 10 = 16-bit. After each acknowledged read, the source address advances by the width in bytes if control bit 2 is set, and otherwise stays fixed. Address, direction and size hold steady until the cycle is acknowledged or errors.
- R4: A write cycle drives the destination address with `bus_wr` high and `bus_size` set to the destination width, which is held in control bits [7:6] with the same encoding. After each acknowledged write, the destination advances by its width if control bit 3 is set, and the byte count drops by the bytes written. The count never goes below zero.
- R5: Data moves in units of the larger of the two widths. Each unit takes unit/source-width reads followed by unit/destination-width writes. Bytes are packed little-endian, so with both addresses incrementing the destination receives an exact copy of the source.
- R6: When the count reaches zero, status bit 0 (done) is set, busy (status bit 1) clears and the bus request drops. Otherwise the next unit begins.
- R7: Control bits [10:8] hold a value n. When n is non-zero and a write leaves a non-zero count that is a multiple of 2^(n+8) bytes, the bus request goes low for exactly one cycle and is then raised again. When n is 0, the request stays high from the first acquire until the run ends.
- R8: An error on any read or write cycle sets status bit 3 (bus error) and done. After that the channel starts no further bus cycles.
- R9: A reserved width (11), a source address not aligned to the source width, a destination address not aligned to its width, a count of zero, or a count that is not a multiple of the unit each set status bit 4 (configuration error). In that case the bus is never requested and done stays clear.
- R10: Status bit 2 (request accepted) is set when a start passes the configuration check.
- R11: `irq` is high exactly while control bit 11 (interrupt enable) is set and any of done, bus error or configuration error is set.
- R12: Writing a 1 to status bit 0 clears done, request accepted, bus error and configuration error. While busy, register writes of every kind are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| dreq | input | 1 | External transfer request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Cycle address |
| bus_size | output | 2 | Operand width code of the cycle |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ack | input | 1 | Successful termination of the cycle |
| bus_err | input | 1 | Error termination of the cycle |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-behaved bus partner:
- Grant stays high for as long as the request is held.
- `bus_ack` and `bus_err` are never high together.
- A termination is given only during a cycle, and at most one per cycle.

The bench stays within these limits. Its responder mirrors the request onto grant half a cycle later. It answers each cycle with exactly one of acknowledge or error, then holds both low for a cycle. The external request is only pulsed for a single cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ACQUIRE,
        ST_RD,
        ST_WR,
        ST_YIELD
    } chan_state_e;

    localparam logic [1:0] SZ_32  = 2'b00;
    localparam logic [1:0] SZ_8   = 2'b01;
    localparam logic [1:0] SZ_16  = 2'b10;

    localparam logic [2:0] IDX_SRC  = 3'd0;
    localparam logic [2:0] IDX_DST  = 3'd1;
    localparam logic [2:0] IDX_CNT  = 3'd2;
    localparam logic [2:0] IDX_CTRL = 3'd3;
    localparam logic [2:0] IDX_STAT = 3'd4;

    // bytes per operand for a width code; 0 marks the reserved code
    function automatic logic [2:0] size_bytes(input logic [1:0] enc);
        logic [2:0] r;
        unique case (enc)
            SZ_32:   r = 3'd4;
            SZ_8:    r = 3'd1;
            SZ_16:   r = 3'd2;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic [1:0]        ssize,
    input  logic [1:0]        dsize,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  count,
    output logic              cfg_bad
);

    logic [2:0] sb, db, unit;
    logic [2:0] s_mask, d_mask, u_mask;
    logic       bad_code, bad_src, bad_dst, bad_cnt;

    always_comb begin
        sb       = size_bytes(ssize);
        db       = size_bytes(dsize);
        unit     = (sb > db) ? sb : db;
        s_mask   = sb - 3'd1;
        d_mask   = db - 3'd1;
        u_mask   = unit - 3'd1;
        bad_code = (sb == 3'd0) || (db == 3'd0);
        bad_src  = (src_addr[2:0] & s_mask) != 3'd0;
        bad_dst  = (dst_addr[2:0] & d_mask) != 3'd0;
        bad_cnt  = (count == '0) || ((count[2:0] & u_mask) != 3'd0);
        cfg_bad  = bad_code || bad_src || bad_dst || bad_cnt;
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int BWC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cfg_bad,
    input  logic [1:0]       ssize,
    input  logic [1:0]       dsize,
    input  logic [BWC_W-1:0] bwc,
    input  logic [CNT_W-1:0] count,
    input  logic             bus_gnt,
    input  logic             bus_ack,
    input  logic             bus_err,
    input  logic [31:0]      bus_rdata,
    output logic             bus_req,
    output logic             bus_cyc,
    output logic             bus_wr,
    output logic [1:0]       bus_size,
    output logic [31:0]      bus_wdata,
    output logic             src_adv,
    output logic             dst_adv,
    output logic             cnt_dec,
    output logic             ev_accept,
    output logic             ev_ce,
    output logic             ev_done,
    output logic             ev_bes,
    output logic             go_clr,
    output logic             busy
);

    localparam int BND_BASE = 8;
    localparam int SH_W     = BWC_W + 2;

    chan_state_e state_q, state_d;
    logic [2:0]  rd_off_q, wr_off_q;
    logic [31:0] hold_q, hold_d, lane, wshift;
    logic [2:0]  sb, db, unit;
    logic        rd_last, wr_last, rd_ok, wr_ok, at_bnd, cnt_zero;
    logic [CNT_W-1:0] cnt_after, bnd_mask;
    logic [SH_W-1:0]  bnd_sh;

    always_comb begin
        sb        = size_bytes(ssize);
        db        = size_bytes(dsize);
        unit      = (sb > db) ? sb : db;
        rd_last   = (rd_off_q + sb) == unit;
        wr_last   = (wr_off_q + db) == unit;
        rd_ok     = (state_q == ST_RD) && bus_ack && !bus_err;
        wr_ok     = (state_q == ST_WR) && bus_ack && !bus_err;
        cnt_after = count - CNT_W'(db);
        cnt_zero  = (cnt_after == '0);
        bnd_sh    = SH_W'(bwc) + SH_W'(BND_BASE);
        bnd_mask  = (CNT_W'(1) << bnd_sh) - CNT_W'(1);
        at_bnd    = (bwc != '0) && ((cnt_after & bnd_mask) == '0);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_req) state_d = ST_CHECK;
            ST_CHECK:   state_d = cfg_bad ? ST_IDLE : ST_ACQUIRE;
            ST_ACQUIRE: if (bus_gnt) state_d = ST_RD;
            ST_RD: begin
                if (bus_err)                 state_d = ST_IDLE;
                else if (bus_ack && rd_last) state_d = ST_WR;
            end
            ST_WR: begin
                if (bus_err) state_d = ST_IDLE;
                else if (bus_ack && wr_last) begin
                    if (cnt_zero)    state_d = ST_IDLE;
                    else if (at_bnd) state_d = ST_YIELD;
                    else             state_d = ST_RD;
                end
            end
            ST_YIELD:   state_d = ST_ACQUIRE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_cyc   = 1'b0;
        bus_wr    = 1'b0;
        bus_size  = ssize;
        ev_accept = 1'b0;
        ev_ce     = 1'b0;
        ev_bes    = 1'b0;
        go_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CHECK: begin
                ev_accept = !cfg_bad;
                ev_ce     = cfg_bad;
                go_clr    = cfg_bad;
            end
            ST_ACQUIRE: begin
                bus_req = 1'b1;
                go_clr  = bus_gnt;
            end
            ST_RD: begin
                bus_req = 1'b1;
                bus_cyc = 1'b1;
                ev_bes  = bus_err;
            end
            ST_WR: begin
                bus_req  = 1'b1;
                bus_cyc  = 1'b1;
                bus_wr   = 1'b1;
                bus_size = dsize;
                ev_bes   = bus_err;
            end
            ST_YIELD:   ;
            default:    ;
        endcase
        src_adv = rd_ok;
        dst_adv = wr_ok;
        cnt_dec = wr_ok;
        ev_done = ev_bes || (wr_ok && wr_last && cnt_zero);
        busy    = (state_q != ST_IDLE);
    end

    // byte-lane packing of read data into the holding register
    always_comb begin
        hold_d = hold_q;
        lane   = '0;
        for (int b = 0; b < 4; b++) begin
            if ((3'(b) >= rd_off_q) && (3'(b) < (rd_off_q + sb))) begin
                lane = bus_rdata >> (8 * (3'(b) - rd_off_q));
                hold_d[8*b +: 8] = lane[7:0];
            end
        end
    end

    // unpacking of the holding register for writes
    always_comb begin
        wshift = hold_q >> {wr_off_q, 3'b000};
        unique case (db)
            3'd1:    bus_wdata = {24'd0, wshift[7:0]};
            3'd2:    bus_wdata = {16'd0, wshift[15:0]};
            default: bus_wdata = wshift;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_off_q <= '0;
            wr_off_q <= '0;
            hold_q   <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                rd_off_q <= '0;
                wr_off_q <= '0;
            end
            if (rd_ok) begin
                hold_q   <= hold_d;
                rd_off_q <= rd_last ? 3'd0 : (rd_off_q + sb);
            end
            if (wr_ok) begin
                wr_off_q <= wr_last ? 3'd0 : (wr_off_q + db);
            end
        end
    end

    // R8
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_err) |=> !bus_cyc);

    // R7
    yield_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_YIELD) |=> (bus_req && (state_q == ST_ACQUIRE)));

    // R7
    cyc_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> bus_req);

    // R3
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack && !bus_err) |=>
            (bus_cyc && $stable(bus_wr) && $stable(bus_size)));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int BWC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              src_adv,
    input  logic              dst_adv,
    input  logic              cnt_dec,
    input  logic              ev_accept,
    input  logic              ev_ce,
    input  logic              ev_done,
    input  logic              ev_bes,
    input  logic              go_clr,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output logic              go,
    output logic              ext_en,
    output logic [1:0]        ssize,
    output logic [1:0]        dsize,
    output logic [BWC_W-1:0]  bwc,
    output logic              irq
);

    localparam int BWC_LSB = 8;

    logic sinc_q, dinc_q, ie_q;
    logic done_q, req_q, bes_q, ce_q;
    logic wr_ok;
    logic [2:0] sb, db;

    always_comb begin
        wr_ok = reg_we && !busy;
        sb    = size_bytes(ssize);
        db    = size_bytes(dsize);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            count    <= '0;
            go       <= 1'b0;
            ext_en   <= 1'b0;
            sinc_q   <= 1'b0;
            dinc_q   <= 1'b0;
            ssize    <= '0;
            dsize    <= '0;
            bwc      <= '0;
            ie_q     <= 1'b0;
            done_q   <= 1'b0;
            req_q    <= 1'b0;
            bes_q    <= 1'b0;
            ce_q     <= 1'b0;
        end else begin
            if (wr_ok && reg_addr == IDX_SRC)    src_addr <= reg_wdata[ADDR_W-1:0];
            else if (src_adv && sinc_q)          src_addr <= src_addr + ADDR_W'(sb);

            if (wr_ok && reg_addr == IDX_DST)    dst_addr <= reg_wdata[ADDR_W-1:0];
            else if (dst_adv && dinc_q)          dst_addr <= dst_addr + ADDR_W'(db);

            if (wr_ok && reg_addr == IDX_CNT)    count <= reg_wdata[CNT_W-1:0];
            else if (cnt_dec)                    count <= count - CNT_W'(db);

            if (wr_ok && reg_addr == IDX_CTRL) begin
                go     <= reg_wdata[0];
                ext_en <= reg_wdata[1];
                sinc_q <= reg_wdata[2];
                dinc_q <= reg_wdata[3];
                ssize  <= reg_wdata[5:4];
                dsize  <= reg_wdata[7:6];
                bwc    <= reg_wdata[BWC_LSB +: BWC_W];
                ie_q   <= reg_wdata[11];
            end else if (go_clr) begin
                go <= 1'b0;
            end

            if (wr_ok && reg_addr == IDX_STAT && reg_wdata[0]) begin
                done_q <= 1'b0;
                req_q  <= 1'b0;
                bes_q  <= 1'b0;
                ce_q   <= 1'b0;
            end else begin
                if (ev_done)   done_q <= 1'b1;
                if (ev_accept) req_q  <= 1'b1;
                if (ev_bes)    bes_q  <= 1'b1;
                if (ev_ce)     ce_q   <= 1'b1;
            end
        end
    end

    always_comb begin
        irq = ie_q && (done_q || bes_q || ce_q);
        unique case (reg_addr)
            IDX_SRC:  reg_rdata = 32'(src_addr);
            IDX_DST:  reg_rdata = 32'(dst_addr);
            IDX_CNT:  reg_rdata = 32'(count);
            IDX_CTRL: reg_rdata = 32'({ie_q, bwc, dsize, ssize, dinc_q, sinc_q, ext_en, go});
            IDX_STAT: reg_rdata = {27'd0, ce_q, bes_q, req_q, busy, done_q};
            default:  reg_rdata = '0;
        endcase
    end

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dec |-> (count >= CNT_W'(db)));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int BWC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dreq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cyc,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              irq
);

    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0]  count;
    logic              go, ext_en, busy, cfg_bad, start_req;
    logic [1:0]        ssize, dsize;
    logic [BWC_W-1:0]  bwc;
    logic src_adv, dst_adv, cnt_dec, ev_accept, ev_ce, ev_done, ev_bes, go_clr;

    assign start_req = go || (ext_en && dreq);
    assign bus_addr  = bus_wr ? dst_addr : src_addr;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BWC_W(BWC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .src_adv(src_adv), .dst_adv(dst_adv), .cnt_dec(cnt_dec),
        .ev_accept(ev_accept), .ev_ce(ev_ce), .ev_done(ev_done), .ev_bes(ev_bes),
        .go_clr(go_clr),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(count),
        .go(go), .ext_en(ext_en), .ssize(ssize), .dsize(dsize), .bwc(bwc), .irq(irq)
    );

    dma_cfg_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_check (
        .ssize(ssize), .dsize(dsize), .src_addr(src_addr), .dst_addr(dst_addr),
        .count(count), .cfg_bad(cfg_bad)
    );

    dma_xfer_fsm #(.CNT_W(CNT_W), .BWC_W(BWC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_bad(cfg_bad),
        .ssize(ssize), .dsize(dsize), .bwc(bwc), .count(count),
        .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_cyc(bus_cyc), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_wdata(bus_wdata),
        .src_adv(src_adv), .dst_adv(dst_adv), .cnt_dec(cnt_dec),
        .ev_accept(ev_accept), .ev_ce(ev_ce), .ev_done(ev_done), .ev_bes(ev_bes),
        .go_clr(go_clr), .busy(busy)
    );

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack && !bus_err) |=> $stable(bus_addr));

    // R9
    ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ce |=> (!bus_req && !busy));

endmodule

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dreq = 1'b0;
    logic        bus_req, bus_cyc, bus_wr, irq;
    logic        bus_gnt = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_size;

    dma_chan_engine u_dma_chan_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq)
    );

    initial forever #10 clk = ~clk;

    logic [7:0] mem [0:4095];
    int  n_chk = 0, n_bad = 0;
    int  cyc_cnt = 0, wr_cnt = 0, fall_cnt = 0;
    bit  err_arm = 0;
    logic [31:0] err_addr = '0;
    logic prev_req = 1'b0;

    function automatic int nbytes(input logic [1:0] enc);
        return (enc == 2'b00) ? 4 : (enc == 2'b01) ? 1 : (enc == 2'b10) ? 2 : 0;
    endfunction

    function automatic logic [31:0] cw(bit go, bit ext, bit si, bit di,
                                       logic [1:0] ss, logic [1:0] ds,
                                       logic [2:0] bw, bit ie);
        return {20'd0, ie, bw, ds, ss, di, si, ext, go};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus responder: grant mirrors request, one termination per access
    initial begin
        forever begin
            @(negedge clk);
            if (prev_req && !bus_req) fall_cnt++;
            prev_req = bus_req;
            bus_gnt  = bus_req;
            if (bus_ack || bus_err) begin
                bus_ack = 1'b0;
                bus_err = 1'b0;
            end else if (bus_cyc) begin
                cyc_cnt++;
                if (err_arm && bus_addr == err_addr) begin
                    bus_err = 1'b1;
                end else begin
                    bus_ack = 1'b1;
                    if (bus_wr) begin
                        wr_cnt++;
                        for (int k = 0; k < nbytes(bus_size); k++)
                            mem[12'(bus_addr + 32'(k))] = bus_wdata[8*k +: 8];
                    end else begin
                        bus_rdata = '0;
                        for (int k = 0; k < nbytes(bus_size); k++)
                            bus_rdata[8*k +: 8] = mem[12'(bus_addr + 32'(k))];
                    end
                end
            end
        end
    end

    task automatic wreg(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = idx;
        #1 d = reg_rdata;
    endtask

    task automatic wait_end();
        logic [31:0] s;
        for (int i = 0; i < 30000; i++) begin
            rreg(3'd4, s);
            if (!s[1] && (s[0] || s[4])) return;
        end
        chk(1'b0, "R6 run never ended", s, 32'h1);
    endtask

    task automatic prep(input logic [31:0] src, input logic [31:0] dst, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            mem[12'(src + 32'(i))] = 8'(i * 7 + seed);
            mem[12'(dst + 32'(i))] = 8'hEE;
        end
        wreg(3'd4, 32'h1);
        wreg(3'd0, src);
        wreg(3'd1, dst);
        wreg(3'd2, 32'(n));
        cyc_cnt = 0; wr_cnt = 0; fall_cnt = 0;
    endtask

    task automatic check_copy(input logic [31:0] src, input logic [31:0] dst, input int n, input string tag);
        int miss = 0;
        for (int i = 0; i < n; i++)
            if (mem[12'(dst + 32'(i))] !== mem[12'(src + 32'(i))]) miss++;
        chk(miss == 0, tag, 32'(miss), 32'h0);
    endtask

    logic [31:0] rv;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < 5; r++) begin
            rreg(3'(r), rv);
            chk(rv == 0, "R1 reset register", rv, 32'h0);
        end
        chk(!bus_req && !bus_cyc && !irq, "R1 reset outputs", {bus_req, bus_cyc, irq}, 32'h0);

        // R5 R3 R4 R6 R10: width sweep with both addresses incrementing
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d < 3; d++) begin
                for (int m = 0; m < 2; m++) begin
                    int n, sb, db;
                    n  = (m == 0) ? 4 : 12;
                    sb = nbytes(2'(s));
                    db = nbytes(2'(d));
                    prep(32'h100, 32'h900, n, s * 3 + d);
                    wreg(3'd3, cw(1, 0, 1, 1, 2'(s), 2'(d), 3'd0, 1));
                    wait_end();
                    check_copy(32'h100, 32'h900, n, "R5 copied data");
                    chk(cyc_cnt == n / sb + n / db, "R5 access count", 32'(cyc_cnt), 32'(n / sb + n / db));
                    rreg(3'd4, rv);
                    chk(rv == 32'h5, "R6 R10 status after copy", rv, 32'h5);
                    rreg(3'd0, rv);
                    chk(rv == 32'h100 + 32'(n), "R3 source advanced", rv, 32'h100 + 32'(n));
                    rreg(3'd1, rv);
                    chk(rv == 32'h900 + 32'(n), "R4 destination advanced", rv, 32'h900 + 32'(n));
                    rreg(3'd2, rv);
                    chk(rv == 0, "R4 count drained", rv, 32'h0);
                    chk(irq, "R11 irq on done", {31'd0, irq}, 32'h1);
                end
            end
        end

        // R2: go bit self-clears
        rreg(3'd3, rv);
        chk(rv[0] == 1'b0, "R2 go cleared", rv, rv & ~32'h1);

        // R12: status clear
        wreg(3'd4, 32'h1);
        rreg(3'd4, rv);
        chk(rv == 0, "R12 status cleared", rv, 32'h0);
        chk(!irq, "R11 irq low after clear", {31'd0, irq}, 32'h0);

        // R4: fixed destination, 8-bit reads into 32-bit writes
        prep(32'h200, 32'hA00, 8, 5);
        wreg(3'd3, cw(1, 0, 1, 0, 2'b01, 2'b00, 3'd0, 0));
        wait_end();
        rreg(3'd1, rv);
        chk(rv == 32'hA00, "R4 fixed destination", rv, 32'hA00);
        chk({mem[12'hA03], mem[12'hA02], mem[12'hA01], mem[12'hA00]} ==
            {mem[12'h207], mem[12'h206], mem[12'h205], mem[12'h204]}, "R4 last unit at fixed dst",
            {mem[12'hA03], mem[12'hA02], mem[12'hA01], mem[12'hA00]},
            {mem[12'h207], mem[12'h206], mem[12'h205], mem[12'h204]});
        chk(!irq, "R11 irq masked", {31'd0, irq}, 32'h0);

        // R3: fixed source, 32-bit reads into 8-bit writes
        prep(32'h300, 32'hB00, 8, 9);
        wreg(3'd3, cw(1, 0, 0, 1, 2'b00, 2'b01, 3'd0, 0));
        wait_end();
        rreg(3'd0, rv);
        chk(rv == 32'h300, "R3 fixed source", rv, 32'h300);
        chk(mem[12'hB04] == mem[12'h300] && mem[12'hB07] == mem[12'h303], "R3 fixed source data",
            {mem[12'hB04], mem[12'hB07]}, {mem[12'h300], mem[12'h303]});

        // R9: configuration errors
        for (int c = 0; c < 5; c++) begin
            logic [31:0] sa, da, nb;
            logic [1:0]  ss, ds;
            sa = 32'h400; da = 32'hC00; nb = 32'd16; ss = 2'b00; ds = 2'b00;
            case (c)
                0: sa = 32'h402;
                1: begin da = 32'hC01; ds = 2'b10; end
                2: nb = 32'd6;
                3: nb = 32'd0;
                default: ss = 2'b11;
            endcase
            prep(sa, da, 1, 1);
            wreg(3'd2, nb);
            wreg(3'd3, cw(1, 0, 1, 1, ss, ds, 3'd0, 1));
            wait_end();
            rreg(3'd4, rv);
            chk(rv == 32'h10, "R9 config error status", rv, 32'h10);
            chk(cyc_cnt == 0 && fall_cnt == 0, "R9 no bus activity", 32'(cyc_cnt), 32'h0);
            chk(irq, "R11 irq on config error", {31'd0, irq}, 32'h1);
            rreg(3'd3, rv);
            chk(rv[0] == 1'b0, "R2 go cleared after reject", rv, rv & ~32'h1);
        end

        // R8: read error and write error
        for (int e = 0; e < 2; e++) begin
            prep(32'h500, 32'hD00, 16, 3);
            err_arm  = 1;
            err_addr = (e == 0) ? 32'h508 : 32'hD04;
            wreg(3'd3, cw(1, 0, 1, 1, 2'b00, 2'b00, 3'd0, 1));
            wait_end();
            repeat (4) @(negedge clk);
            err_arm = 0;
            rreg(3'd4, rv);
            chk(rv == 32'hD, "R8 error status", rv, 32'hD);
            chk(wr_cnt == ((e == 0) ? 2 : 1), "R8 no writes after error", 32'(wr_cnt), (e == 0) ? 32'd2 : 32'd1);
            chk(cyc_cnt == ((e == 0) ? 5 : 4), "R8 no cycles after error", 32'(cyc_cnt), (e == 0) ? 32'd5 : 32'd4);
            chk(irq, "R11 irq on error", {31'd0, irq}, 32'h1);
        end

        // R2: external enable without and with a request pulse
        prep(32'h600, 32'hE00, 8, 11);
        wreg(3'd3, cw(0, 1, 1, 1, 2'b00, 2'b00, 3'd0, 0));
        repeat (20) @(negedge clk);
        rreg(3'd4, rv);
        chk(rv == 0 && cyc_cnt == 0, "R2 no start without dreq", rv, 32'h0);
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        wait_end();
        check_copy(32'h600, 32'hE00, 8, "R2 external start copy");

        // R12: writes while busy are ignored
        prep(32'h000, 32'h800, 64, 13);
        wreg(3'd3, cw(1, 0, 1, 1, 2'b00, 2'b00, 3'd0, 0));
        repeat (4) @(negedge clk);
        wreg(3'd0, 32'h777);
        wreg(3'd4, 32'h1);
        wait_end();
        rreg(3'd0, rv);
        chk(rv == 32'h40, "R12 busy write ignored", rv, 32'h40);
        rreg(3'd4, rv);
        chk(rv == 32'h5, "R12 busy status clear ignored", rv, 32'h5);

        // R7: bandwidth boundaries, 2048 bytes: n=0 one release, n=1 four, n=2 two
        for (int b = 0; b < 3; b++) begin
            int exp_f;
            exp_f = (b == 0) ? 1 : (b == 1) ? 4 : 2;
            prep(32'h000, 32'h800, 2048, 17 + b);
            wreg(3'd3, cw(1, 0, 1, 1, 2'b00, 2'b00, 3'(b), 0));
            wait_end();
            repeat (2) @(negedge clk);
            chk(fall_cnt == exp_f, "R7 request releases", 32'(fall_cnt), 32'(exp_f));
            check_copy(32'h000, 32'h800, 2048, "R7 data with bandwidth limit");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule